// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the register front end of a FIFO-based serial port. It sits on a simple memory-mapped bus with single-cycle write and read strobes. It holds the mode, bit-rate, control, FIFO-control and port registers, each stored through its own write mask. It also keeps five status flags: transmit-end, transmit-empty, break, receive-full and data-ready. Software clears a flag by writing a zero to its bit in the status word. Writing a one to a flag bit leaves that flag as it is.

The receive FIFO and the line-level serializer live outside this block. The FIFO side reports to the bank through three single-cycle event pulses: receive-full, data-ready and break-detected. A write to the transmit data offset sends the byte to the serializer as a one-cycle strobe. The transmit interrupt line follows the transmit-interrupt-enable control bit. The receive interrupt line is raised by a receive-full event while receive interrupts are enabled, and it is dropped by clearing writes.

The transmitter is modelled as finishing at once. Reading the status word while transmit is enabled returns the current flags, and transmit-empty and transmit-end are set again on the same clock edge.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset the registers and outputs hold these values. Mode reads 0x00, bit rate 0xFF, control 0x20, FIFO control 0x00 and port 0x00. The status word reads 0x60. tx_irq, rx_irq and txb_valid are low.
- R2: Each register stores the written value ANDed with its mask and reads it back. Mode (offset 0x00) uses mask 0x7B, bit rate (0x04) uses 0xFF, control (0x08) uses 0xFA, FIFO control (0x18) uses 0xFF and port (0x20) uses 0xF3.
- R3: The status word at offset 0x10 packs the flags as follows: bit 6 transmit-end, bit 5 transmit-empty, bit 4 break, bit 1 receive-full, bit 0 data-ready. Bits 7, 3 and 2 read as zero.
- R4: A write to the status word clears every flag whose bit is written as 0. A flag whose bit is written as 1 keeps its value.
- R5: After a clock edge where ev_rdf_set, ev_dr_set or ev_brk is high, the matching flag (receive-full, data-ready or break) is set. A set event wins over a clearing status write in the same cycle.
- R6: A control write with bit 5 (transmit enable) at 0 sets transmit-end. A control write with bit 5 at 1 leaves transmit-end unchanged.
- R7: A write to offset 0x0C clears transmit-empty. In the next cycle txb_valid is high for exactly one cycle, with txb_data equal to the written byte. In every other cycle txb_valid is low.
- R8: A read of the status word while control bit 5 is 1 returns the current flags. After that edge, transmit-empty and transmit-end are both set.
- R9: tx_irq equals control bit 7 from the cycle after each control write.
- R10: rx_irq rises after an ev_rdf_set while control bit 6 is 1. It falls after either of two writes: a status write with bit 1 or bit 0 at 0, or a control write with bit 6 at 0. A rising event wins over a falling write in the same cycle.
- R11: Reads of offsets 0x0C, 0x14, 0x1C and 0x24, and of every other offset outside R2 and R3, return zero. Writes to those offsets change nothing, except the transmit-data behaviour of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational by default) |
| ev_rdf_set | input | 1 | FIFO side: receive level reached |
| ev_dr_set | input | 1 | FIFO side: data waiting with no new arrivals |
| ev_brk | input | 1 | Line side: break condition seen |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| txb_valid | output | 1 | One-cycle strobe carrying a transmit byte |
| txb_data | output | DW | Byte presented with txb_valid |

## Verification
The assertions assume the bus presents a single address per cycle. A status read and a transmit-data write therefore never meet in the same cycle, which is what lets the transmit-empty clear and the read-side refill be stated as separate implications. They also take the event inputs as plain level samples, with no spacing between pulses. The stimulus drives every input half a cycle away from the active edge and uses one bus operation per cycle. It places events both alone and together with clearing writes, so that the same-cycle priority cases are reached without breaking the single-address assumption.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

   // register slots; the byte offset of a slot is four times its index
   localparam int SLOT_MODE = 0;
   localparam int SLOT_RATE = 1;
   localparam int SLOT_CTRL = 2;
   localparam int SLOT_TXD  = 3;
   localparam int SLOT_STAT = 4;
   localparam int SLOT_FCTL = 6;
   localparam int SLOT_PORT = 8;

   // stored configuration registers
   localparam int NUM_CFG  = 5;
   localparam int CFG_CTRL = 2;

   // status flags, internal order
   localparam int NUM_FLAGS = 5;
   localparam int FL_DR   = 0;
   localparam int FL_RDF  = 1;
   localparam int FL_BRK  = 2;
   localparam int FL_TDE  = 3;
   localparam int FL_TEND = 4;

   // control bits with side effects
   localparam int CTRL_TE  = 5;
   localparam int CTRL_RIE = 6;
   localparam int CTRL_TIE = 7;

   function automatic int slot_offset(input int slot);
      return slot * 4;
   endfunction

   function automatic int cfg_slot(input int j);
      case (j)
         0: return SLOT_MODE;
         1: return SLOT_RATE;
         2: return SLOT_CTRL;
         3: return SLOT_FCTL;
         default: return SLOT_PORT;
      endcase
   endfunction

   function automatic int cfg_mask(input int j);
      case (j)
         0: return 'h7B;
         2: return 'hFA;
         4: return 'hF3;
         default: return 'hFF;
      endcase
   endfunction

   function automatic int cfg_reset(input int j);
      case (j)
         1: return 'hFF;
         2: return 'h20;
         default: return 'h00;
      endcase
   endfunction

   // bit of the status word that carries each flag
   function automatic int flag_pos(input int i);
      case (i)
         FL_DR:  return 0;
         FL_RDF: return 1;
         FL_BRK: return 4;
         FL_TDE: return 5;
         default: return 6;
      endcase
   endfunction

endpackage

// File: rtl/csr_field_reg.sv
module csr_field_reg #(
   parameter int             DW    = 8,
   parameter logic [DW-1:0]  MASK  = '1,
   parameter logic [DW-1:0]  RESET = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RESET & MASK;
      else if (we)
         q <= wdata & MASK;
   end

endmodule

// File: rtl/csr_flag_unit.sv
module csr_flag_unit
   import uart_csr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 st_wr,
   input  logic [7:0]           wbyte,
   input  logic                 ctrl_wr,
   input  logic                 txd_wr,
   input  logic                 st_rd_te,
   input  logic                 ev_rdf_set,
   input  logic                 ev_dr_set,
   input  logic                 ev_brk,
   output logic [NUM_FLAGS-1:0] flag_q
);

   localparam logic [NUM_FLAGS-1:0] FLAG_RST =
      NUM_FLAGS'((1 << FL_TDE) | (1 << FL_TEND));

   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] extra_clr;

   always_comb begin
      set_v            = '0;
      set_v[FL_DR]     = ev_dr_set;
      set_v[FL_RDF]    = ev_rdf_set;
      set_v[FL_BRK]    = ev_brk;
      set_v[FL_TDE]    = st_rd_te;
      set_v[FL_TEND]   = st_rd_te | (ctrl_wr & ~wbyte[CTRL_TE]);
      extra_clr         = '0;
      extra_clr[FL_TDE] = txd_wr;
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      localparam int POS = flag_pos(i);
      logic bit_q;
      logic clr;

      assign clr = (st_wr & ~wbyte[POS]) | extra_clr[i];

      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= FLAG_RST[i];
         else if (set_v[i])
            bit_q <= 1'b1;
         else if (clr)
            bit_q <= 1'b0;
      end

      assign flag_q[i] = bit_q;
   end

endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
   import uart_csr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rdf_evt,
   input  logic       rie,
   input  logic       tie,
   input  logic       st_wr,
   input  logic       ctrl_wr,
   input  logic [7:0] wbyte,
   output logic       rx_irq,
   output logic       tx_irq
);

   logic rx_q;
   logic rx_rise;
   logic rx_fall;

   assign rx_rise = rdf_evt & rie;
   assign rx_fall = (st_wr & ~(wbyte[FL_RDF] & wbyte[FL_DR]))
                  | (ctrl_wr & ~wbyte[CTRL_RIE]);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_q <= 1'b0;
      else if (rx_rise)
         rx_q <= 1'b1;
      else if (rx_fall)
         rx_q <= 1'b0;
   end

   assign rx_irq = rx_q;
   assign tx_irq = tie;

endmodule

// File: rtl/csr_tx_strobe.sv
module csr_tx_strobe #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txd_wr,
   input  logic [DW-1:0] wdata,
   output logic          txb_valid,
   output logic [DW-1:0] txb_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txb_valid <= 1'b0;
         txb_data  <= '0;
      end else begin
         txb_valid <= txd_wr;
         if (txd_wr)
            txb_data <= wdata;
      end
   end

endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
   import uart_csr_pkg::*;
#(
   parameter int AW        = 6,
   parameter int DW        = 8,
   parameter int READ_PIPE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ev_rdf_set,
   input  logic          ev_dr_set,
   input  logic          ev_brk,
   output logic          tx_irq,
   output logic          rx_irq,
   output logic          txb_valid,
   output logic [DW-1:0] txb_data
);

   // elaboration-time parameter checks
   if (DW < 8) begin : g_dw_bad
      $error("uart_csr_bank: DW must be at least 8");
   end
   if (AW < 6) begin : g_aw_bad
      $error("uart_csr_bank: AW must cover offset 0x24");
   end
   if (READ_PIPE != 0 && READ_PIPE != 1) begin : g_rp_bad
      $error("uart_csr_bank: READ_PIPE must be 0 or 1");
   end

   localparam logic [AW-1:0] A_TXD  = AW'(slot_offset(SLOT_TXD));
   localparam logic [AW-1:0] A_STAT = AW'(slot_offset(SLOT_STAT));

   logic [DW-1:0]        cfg_q [NUM_CFG];
   logic [NUM_CFG-1:0]   cfg_hit;
   logic                 hit_txd;
   logic                 hit_stat;
   logic [DW-1:0]        ctrl_q;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [DW-1:0]        stat_word;
   logic [DW-1:0]        rd_mux;
   logic                 st_wr;
   logic                 ctrl_wr;
   logic                 txd_wr;
   logic                 st_rd_te;

   // configuration registers, one instance per slot
   for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
      localparam logic [AW-1:0] ADDR = AW'(slot_offset(cfg_slot(j)));
      assign cfg_hit[j] = (bus_addr == ADDR);
      csr_field_reg #(
         .DW    (DW),
         .MASK  (DW'(cfg_mask(j))),
         .RESET (DW'(cfg_reset(j)))
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bus_wr & cfg_hit[j]),
         .wdata (bus_wdata),
         .q     (cfg_q[j])
      );
   end

   assign hit_txd  = (bus_addr == A_TXD);
   assign hit_stat = (bus_addr == A_STAT);
   assign ctrl_q   = cfg_q[CFG_CTRL];
   assign st_wr    = bus_wr & hit_stat;
   assign ctrl_wr  = bus_wr & cfg_hit[CFG_CTRL];
   assign txd_wr   = bus_wr & hit_txd;
   assign st_rd_te = bus_rd & hit_stat & ctrl_q[CTRL_TE];

   csr_flag_unit u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_wr      (st_wr),
      .wbyte      (bus_wdata[7:0]),
      .ctrl_wr    (ctrl_wr),
      .txd_wr     (txd_wr),
      .st_rd_te   (st_rd_te),
      .ev_rdf_set (ev_rdf_set),
      .ev_dr_set  (ev_dr_set),
      .ev_brk     (ev_brk),
      .flag_q     (flag_q)
   );

   csr_irq_unit u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdf_evt (ev_rdf_set),
      .rie     (ctrl_q[CTRL_RIE]),
      .tie     (ctrl_q[CTRL_TIE]),
      .st_wr   (st_wr),
      .ctrl_wr (ctrl_wr),
      .wbyte   (bus_wdata[7:0]),
      .rx_irq  (rx_irq),
      .tx_irq  (tx_irq)
   );

   csr_tx_strobe #(.DW(DW)) u_txs (
      .clk       (clk),
      .rst_n     (rst_n),
      .txd_wr    (txd_wr),
      .wdata     (bus_wdata),
      .txb_valid (txb_valid),
      .txb_data  (txb_data)
   );

   // status word packing
   always_comb begin
      stat_word = '0;
      for (int i = 0; i < NUM_FLAGS; i++)
         stat_word[flag_pos(i)] = flag_q[i];
   end

   // read selection; offsets not listed read zero
   always_comb begin
      rd_mux = '0;
      for (int j = 0; j < NUM_CFG; j++)
         if (cfg_hit[j])
            rd_mux = cfg_q[j];
      if (hit_stat)
         rd_mux = stat_word;
   end

   if (READ_PIPE == 0) begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end else begin : g_rd_reg
      logic [DW-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rd_q <= '0;
         else
            rd_q <= bus_rd ? rd_mux : '0;
      end
      assign bus_rdata = rd_q;
   end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
   import uart_csr_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [AW-1:0]        bus_addr,
   input logic [DW-1:0]        bus_wdata,
   input logic                 ev_rdf_set,
   input logic                 ev_dr_set,
   input logic                 ev_brk,
   input logic                 tx_irq,
   input logic                 rx_irq,
   input logic                 txb_valid,
   input logic [DW-1:0]        txb_data,
   input logic [NUM_FLAGS-1:0] flag_q,
   input logic [DW-1:0]        ctrl_q
);

   localparam logic [AW-1:0] C_CTRL = AW'(slot_offset(SLOT_CTRL));
   localparam logic [AW-1:0] C_TXD  = AW'(slot_offset(SLOT_TXD));
   localparam logic [AW-1:0] C_STAT = AW'(slot_offset(SLOT_STAT));

   logic w_ctrl, w_txd, w_stat, r_stat;
   assign w_ctrl = bus_wr && bus_addr == C_CTRL;
   assign w_txd  = bus_wr && bus_addr == C_TXD;
   assign w_stat = bus_wr && bus_addr == C_STAT;
   assign r_stat = bus_rd && bus_addr == C_STAT;

   // R5
   rdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rdf_set |=> flag_q[FL_RDF]);
   // R5
   dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_dr_set |=> flag_q[FL_DR]);
   // R5
   brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_brk |=> flag_q[FL_BRK]);
   // R4
   rdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stat && !bus_wdata[1] && !ev_rdf_set) |=> !flag_q[FL_RDF]);
   // R4
   brk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stat && bus_wdata[4]) |=> flag_q[FL_BRK] == ($past(flag_q[FL_BRK]) || $past(ev_brk)));
   // R6
   tend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && !bus_wdata[CTRL_TE]) |=> flag_q[FL_TEND]);
   // R7
   txb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_txd |=> (txb_valid && txb_data == $past(bus_wdata)));
   // R7
   txb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !w_txd |=> !txb_valid);
   // R7
   tde_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_txd |=> !flag_q[FL_TDE]);
   // R8
   refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_stat && ctrl_q[CTRL_TE]) |=> (flag_q[FL_TDE] && flag_q[FL_TEND]));
   // R9
   tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_ctrl |=> tx_irq == $past(bus_wdata[CTRL_TIE]));
   // R10
   rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rdf_set && ctrl_q[CTRL_RIE]) |=> rx_irq);
   // R10
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && !bus_wdata[CTRL_RIE] && !ev_rdf_set) |=> !rx_irq);

endmodule

bind uart_csr_bank csr_bank_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .ev_rdf_set (ev_rdf_set),
   .ev_dr_set  (ev_dr_set),
   .ev_brk     (ev_brk),
   .tx_irq     (tx_irq),
   .rx_irq     (rx_irq),
   .txb_valid  (txb_valid),
   .txb_data   (txb_data),
   .flag_q     (flag_q),
   .ctrl_q     (ctrl_q)
);

// File: tb/uart_csr_bank_test.sv
module uart_csr_bank_test;

   localparam int AW = 6;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_wr, bus_rd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          ev_rdf_set, ev_dr_set, ev_brk;
   logic          tx_irq, rx_irq, txb_valid;
   logic [DW-1:0] txb_data;

   always #4 clk = ~clk;

   uart_csr_bank #(.AW(AW), .DW(DW)) uut (.*);

   int n_chk  = 0;
   int n_fail = 0;

   // reference state, updated from the requirements
   logic [7:0] m_mode, m_rate, m_ctrl, m_fctl, m_port, m_txd;
   bit m_tend, m_tde, m_brk, m_rdf, m_dr, m_rx, m_txv;

   function automatic logic [7:0] m_status();
      return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
   endfunction

   function automatic logic [7:0] m_read(input logic [5:0] a);
      case (a)
         6'h00:   return m_mode;
         6'h04:   return m_rate;
         6'h08:   return m_ctrl;
         6'h10:   return m_status();
         6'h18:   return m_fctl;
         6'h20:   return m_port;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle with optional events; checks outputs from the previous edge
   task automatic cyc(input bit wr, input bit rd, input logic [5:0] a, input logic [7:0] d,
                      input bit er, input bit ed, input bit eb, input string tag);
      bit st_wr, ctrl_wr, txd_wr, st_rd;
      @(negedge clk);
      check("R9 tx_irq", {31'd0, tx_irq}, {31'd0, m_ctrl[7]});
      check("R10 rx_irq", {31'd0, rx_irq}, {31'd0, m_rx});
      check("R7 txb_valid", {31'd0, txb_valid}, {31'd0, m_txv});
      if (m_txv) check("R7 txb_data", {24'd0, txb_data}, {24'd0, m_txd});
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      ev_rdf_set = er; ev_dr_set = ed; ev_brk = eb;
      #1;
      if (rd) check(tag, {24'd0, bus_rdata}, {24'd0, m_read(a)});
      st_wr   = wr && a == 6'h10;
      ctrl_wr = wr && a == 6'h08;
      txd_wr  = wr && a == 6'h0C;
      st_rd   = rd && a == 6'h10 && m_ctrl[5];
      if (er && m_ctrl[6]) m_rx = 1;
      else if ((st_wr && !(d[1] && d[0])) || (ctrl_wr && !d[6])) m_rx = 0;
      if ((ctrl_wr && !d[5]) || st_rd) m_tend = 1; else if (st_wr && !d[6]) m_tend = 0;
      if (st_rd) m_tde = 1; else if ((st_wr && !d[5]) || txd_wr) m_tde = 0;
      if (eb) m_brk = 1; else if (st_wr && !d[4]) m_brk = 0;
      if (er) m_rdf = 1; else if (st_wr && !d[1]) m_rdf = 0;
      if (ed) m_dr = 1;  else if (st_wr && !d[0]) m_dr = 0;
      m_txv = txd_wr;
      if (txd_wr) m_txd = d;
      if (wr) begin
         case (a)
            6'h00: m_mode = d & 8'h7B;
            6'h04: m_rate = d;
            6'h08: m_ctrl = d & 8'hFA;
            6'h18: m_fctl = d;
            6'h20: m_port = d & 8'hF3;
            default: ;
         endcase
      end
      @(posedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag);
      cyc(1, 0, a, d, 0, 0, 0, tag);
   endtask

   task automatic rd(input logic [5:0] a, input string tag);
      cyc(0, 1, a, 8'h00, 0, 0, 0, tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] w;
      rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
      ev_rdf_set = 0; ev_dr_set = 0; ev_brk = 0;
      m_mode = 8'h00; m_rate = 8'hFF; m_ctrl = 8'h20; m_fctl = 8'h00; m_port = 8'h00;
      m_txd = 8'h00; m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_rx = 0; m_txv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      check("R1 tx_irq", {31'd0, tx_irq}, 32'd0);
      check("R1 rx_irq", {31'd0, rx_irq}, 32'd0);
      check("R1 txb_valid", {31'd0, txb_valid}, 32'd0);
      rd(6'h00, "R1 mode");
      rd(6'h04, "R1 rate");
      rd(6'h08, "R1 ctrl");
      rd(6'h18, "R1 fifo ctrl");
      rd(6'h20, "R1 port");
      rd(6'h10, "R1 status");

      // R2 masked storage sweep
      for (int v = 0; v < 256; v++) begin
         wr(6'h00, 8'(v), "R2"); rd(6'h00, "R2 mode");
         wr(6'h04, 8'(v), "R2"); rd(6'h04, "R2 rate");
         wr(6'h18, 8'(v), "R2"); rd(6'h18, "R2 fifo ctrl");
         wr(6'h20, 8'(v), "R2"); rd(6'h20, "R2 port");
      end

      // R9 / R6 control sweep with status reads in between
      for (int v = 0; v < 256; v++) begin
         wr(6'h08, 8'(v), "R9");
         rd(6'h08, "R2 ctrl");
         rd(6'h10, "R6 status after ctrl");
      end

      // R4 / R3 clear-on-zero sweep over all flag patterns
      for (int p = 0; p < 32; p++) begin
         wr(6'h08, 8'h20, "R8");
         rd(6'h10, "R8 refill");
         wr(6'h08, 8'h40, "R6");
         cyc(0, 0, 6'h00, 8'h00, 1, 1, 1, "R5");
         rd(6'h10, "R5 all set");
         w = {p[0], p[4], p[3], p[2], p[1], p[2], p[1], p[0]};
         wr(6'h10, w, "R4");
         rd(6'h10, "R4 after clear");
         rd(6'h10, "R3 layout");
      end

      // R5 set beats same-cycle clear
      wr(6'h08, 8'h40, "R5");
      cyc(1, 0, 6'h10, 8'h00, 1, 1, 1, "R5");
      rd(6'h10, "R5 priority");
      cyc(1, 0, 6'h10, 8'h00, 0, 1, 0, "R5");
      rd(6'h10, "R5 dr only");

      // R7 / R8 transmit data and refill
      wr(6'h08, 8'h20, "R8");
      rd(6'h10, "R8 refill");
      wr(6'h0C, 8'hA5, "R7");
      rd(6'h10, "R8 shows tde clear");
      rd(6'h10, "R8 refilled");
      for (int v = 0; v < 16; v++) wr(6'h0C, 8'(v * 17), "R7");
      cyc(0, 0, 6'h00, 8'h00, 0, 0, 0, "R7");
      rd(6'h10, "R8 after burst");

      // R6 transmit-end set by control write with enable low
      wr(6'h08, 8'h00, "R6");
      wr(6'h10, 8'hBF, "R6");
      rd(6'h10, "R6 cleared");
      wr(6'h08, 8'h80, "R6");
      rd(6'h10, "R6 set");
      wr(6'h10, 8'hBF, "R6");
      wr(6'h08, 8'hA0, "R6");
      rd(6'h10, "R6 unchanged");
      rd(6'h10, "R8 refill again");

      // R10 receive interrupt
      wr(6'h08, 8'h00, "R10");
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, "R10");
      wr(6'h08, 8'h40, "R10");
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, "R10");
      wr(6'h10, 8'hFD, "R10");
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, "R10");
      wr(6'h10, 8'hFE, "R10");
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, "R10");
      wr(6'h10, 8'hFF, "R10");
      wr(6'h08, 8'h00, "R10");
      wr(6'h08, 8'h40, "R10");
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, "R10");
      cyc(1, 0, 6'h08, 8'h00, 1, 0, 0, "R10");
      cyc(1, 0, 6'h10, 8'h00, 0, 0, 0, "R10");

      // R11 unmapped and placeholder offsets
      for (int a = 0; a < 64; a++) begin
         if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h0C && a != 'h10 &&
             a != 'h18 && a != 'h20)
            wr(6'(a), 8'hFF, "R11");
      end
      for (int a = 0; a < 64; a++) rd(6'(a), "R11 read");

      cyc(0, 0, 6'h00, 8'h00, 0, 0, 0, "R11");
      cyc(0, 0, 6'h00, 8'h00, 0, 0, 0, "R11");
      summary();
      $finish;
   end

endmodule